// File: doc/BRIEF.md
# Pipelined NCO Phase Accumulator

This block is the phase engine of a numerically controlled oscillator. A 32-bit tuning word is held in a staging register. Each clock, a 32-bit accumulator adds the staged word to its own value and wraps modulo 2^32. The 13 most significant bits of the accumulator are the phase, which a later stage maps to amplitude. The output frequency is the tuning word times the clock rate divided by 2^32. For example, a word of 0x20000000 gives one eighth of the clock rate.

Three active-low controls steer the block: a transfer strobe, a feedback clear and an accumulate enable. Each control first passes through its own fixed-length register pipeline, and acts only after that pipeline. This keeps them aligned with the other pipelined paths around the oscillator.

- The transfer strobe copies the tuning word into the staging register.
- The clear does not reset the accumulator. It zeroes the feedback term, so the next value equals the staged word. This restarts the phase at a known point.
- The accumulator register itself is a small state machine with three operations: HOLD, STEP and SEED.
  - The delayed enable high selects HOLD. The transition is HOLD → HOLD.
  - The enable low with the clear inactive selects STEP. This gives acc ← acc + word.
  - The enable low with the clear active selects SEED. This gives acc ← word.
  - Any operation can follow any other from one clock to the next.

Top module: `nco_phase_pipe`

## Requirements
- R1: A low on `xfer_n` sampled at clock edge k loads `tune_word` into the staging register at edge k+4, using the `tune_word` present at edge k+4. Otherwise the staging register keeps its value.
- R2: A low on `clr_n` sampled at edge k makes the accumulator take exactly the staged word at edge k+5, provided the delayed enable is active at that edge. This is the SEED operation.
- R3: The accumulator changes only at an edge where the `run_n` value sampled four edges earlier was low. Otherwise it holds its value (HOLD).
- R4: In STEP, the accumulator becomes the previous accumulator plus the staged word, modulo 2^32. A carry out is discarded with no flag.
- R5: `phase_o` equals bits 31 down to 19 of the accumulator at all times.
- R6: After reset, the staging register and the accumulator are zero, `phase_o` is zero, and every control pipeline stage is at its inactive (high) level.
- R7: The staging register can be reloaded by a transfer while the accumulator is held.
- R8: With tuning word 0x20000000 and steady accumulation, `phase_o` advances by 0x400 (mod 2^13) every clock, giving a period of eight clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tune_word | input | 32 | Tuning word offered to the staging register |
| xfer_n | input | 1 | Transfer strobe, active low, acts after 4 clocks |
| clr_n | input | 1 | Feedback clear, active low, acts after 5 clocks |
| run_n | input | 1 | Accumulate enable, active low, acts after 4 clocks |
| phase_o | output | 13 | Top 13 bits of the accumulator |

## Verification
The assertions assume that all three controls, and `tune_word`, are sampled only at rising clock edges and are stable around them. The bench meets this by changing every input at the falling edge. The assertions also assume that the delayed controls reach the accumulator and staging register unmodified, so they relate those registers to the pipeline outputs rather than to the raw pins. Random stimulus drives the controls with low-probability strobes and an enable that is mostly active. This produces long runs of STEP, interleaved with SEED and HOLD and with reloads during hold. Wide random words exercise the 2^32 wrap.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Operation applied to the accumulator register on a clock edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_SEED = 2'd2
    } acc_op_t;

endpackage

// File: rtl/nco_ctl_delay.sv
// Fixed-length delay line for an active-low control; resets to inactive (high).
module nco_ctl_delay #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic dout_n
);

    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '1;
                else        stage_q <= din_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '1;
                else        stage_q <= {stage_q[DEPTH-2:0], din_n};
            end
        end
    endgenerate

    assign dout_n = stage_q[DEPTH-1];

endmodule

// File: rtl/nco_tune_reg.sv
// Staging register in front of the accumulator.
module nco_tune_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer_eff_n,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           word_q <= '0;
        else if (!xfer_eff_n) word_q <= word_in;
    end

endmodule

// File: rtl/nco_phase_acc.sv
// Accumulator register with HOLD / STEP / SEED operations.
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int W  = 32,
    parameter int PW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_eff_n,
    input  logic          clr_eff_n,
    input  logic [W-1:0]  incr,
    output logic [W-1:0]  acc_q,
    output logic [PW-1:0] phase
);

    acc_op_t      op;
    logic [W-1:0] feedback;

    // Operation decode from the delayed controls
    always_comb begin
        unique case ({run_eff_n, clr_eff_n})
            2'b00:        op = OP_SEED;
            2'b01:        op = OP_STEP;
            2'b10, 2'b11: op = OP_HOLD;
            default:      op = OP_HOLD;
        endcase
    end

    // Feedback path is zeroed on SEED; the adder itself is shared
    assign feedback = (op == OP_SEED) ? '0 : acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            unique case (op)
                OP_STEP, OP_SEED: acc_q <= feedback + incr;
                OP_HOLD:          acc_q <= acc_q;
                default:          acc_q <= acc_q;
            endcase
        end
    end

    assign phase = acc_q[W-1 -: PW];

endmodule

// File: rtl/nco_phase_pipe.sv
module nco_phase_pipe #(
    parameter int ACC_W    = 32,
    parameter int PHASE_W  = 13,
    parameter int XFER_DLY = 4,
    parameter int CLR_DLY  = 5,
    parameter int RUN_DLY  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   tune_word,
    input  logic               xfer_n,
    input  logic               clr_n,
    input  logic               run_n,
    output logic [PHASE_W-1:0] phase_o
);

    logic             xfer_n_dly;
    logic             clr_n_dly;
    logic             run_n_dly;
    logic [ACC_W-1:0] tune_q;
    logic [ACC_W-1:0] acc_q;

    nco_ctl_delay #(.DEPTH(XFER_DLY)) u_xfer_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (xfer_n),
        .dout_n (xfer_n_dly)
    );

    nco_ctl_delay #(.DEPTH(CLR_DLY)) u_clr_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (clr_n),
        .dout_n (clr_n_dly)
    );

    nco_ctl_delay #(.DEPTH(RUN_DLY)) u_run_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (run_n),
        .dout_n (run_n_dly)
    );

    nco_tune_reg #(.W(ACC_W)) u_tune (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_eff_n (xfer_n_dly),
        .word_in    (tune_word),
        .word_q     (tune_q)
    );

    nco_phase_acc #(.W(ACC_W), .PW(PHASE_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_eff_n (run_n_dly),
        .clr_eff_n (clr_n_dly),
        .incr      (tune_q),
        .acc_q     (acc_q),
        .phase     (phase_o)
    );

endmodule

// File: rtl/nco_phase_pipe_chk.sv
module nco_phase_pipe_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] tune_word,
    input logic         xfer_d,
    input logic         clr_d,
    input logic         run_d,
    input logic [W-1:0] stage_word,
    input logic [W-1:0] acc
);

    AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_d |=> stage_word == $past(tune_word)); // R1

    AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_d |=> $stable(stage_word)); // R1

    AST_SEED_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_d && !clr_d) |=> acc == $past(stage_word)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        run_d |=> $stable(acc)); // R3

    AST_STEP_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_d && clr_d) |=> acc == $past(acc) + $past(stage_word)); // R4

endmodule

bind nco_phase_pipe nco_phase_pipe_chk #(.W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tune_word  (tune_word),
    .xfer_d     (xfer_n_dly),
    .clr_d      (clr_n_dly),
    .run_d      (run_n_dly),
    .stage_word (tune_q),
    .acc        (acc_q)
);

// File: tb/nco_phase_pipe_tb.sv
`timescale 1ns/1ps
module nco_phase_pipe_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tune_word = '0;
    logic        xfer_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        run_n = 1'b1;
    logic [12:0] phase_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    nco_phase_pipe u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .xfer_n    (xfer_n),
        .clr_n     (clr_n),
        .run_n     (run_n),
        .phase_o   (phase_o)
    );

    // Reference model built from the requirements (delays 4/5/4)
    logic [31:0] m_stage, m_acc;
    logic [5:1]  xh, ch, rh;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stage <= '0;
            m_acc   <= '0;
            xh <= '1;
            ch <= '1;
            rh <= '1;
        end else begin
            if (!rh[4]) m_acc <= (ch[5] ? m_acc : 32'd0) + m_stage;
            if (!xh[4]) m_stage <= tune_word;
            xh <= {xh[4:1], xfer_n};
            ch <= {ch[4:1], clr_n};
            rh <= {rh[4:1], run_n};
        end
    end

    function automatic logic [12:0] exp_phase(input logic [31:0] a);
        return a[31:19];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input string req);
        @(negedge clk);
        chk(req, {19'd0, phase_o}, {19'd0, exp_phase(m_acc)});
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [12:0] prev;
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        chk("R6", {19'd0, phase_o}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cyc("R6");
            chk("R6", {19'd0, phase_o}, 32'd0);
        end

        // R8: eighth-rate tone
        tune_word = 32'h2000_0000;
        xfer_n = 1'b0;
        run_n = 1'b0;
        cyc("R8");
        xfer_n = 1'b1;
        for (int i = 0; i < 12; i++) cyc("R8");
        for (int i = 0; i < 10; i++) begin
            prev = phase_o;
            cyc("R8");
            chk("R8", {19'd0, phase_o - prev}, 32'h400);
        end

        // R3: hold, then R7: reload while held
        run_n = 1'b1;
        for (int i = 0; i < 8; i++) cyc("R3");
        prev = phase_o;
        tune_word = 32'h0123_4567;
        xfer_n = 1'b0;
        cyc("R7");
        xfer_n = 1'b1;
        tune_word = 32'hDEAD_BEEF;
        for (int i = 0; i < 6; i++) begin
            cyc("R7");
            chk("R3", {19'd0, phase_o}, {19'd0, prev});
        end
        run_n = 1'b0;
        for (int i = 0; i < 8; i++) cyc("R7");

        // R2: clear seeds with the staged word
        clr_n = 1'b0;
        cyc("R2");
        clr_n = 1'b1;
        for (int i = 0; i < 8; i++) cyc("R2");

        // R4: wrap with a large word
        tune_word = 32'hFFF0_0001;
        xfer_n = 1'b0;
        cyc("R4");
        xfer_n = 1'b1;
        for (int i = 0; i < 20; i++) cyc("R4");

        // R1: transfer timing with changing word
        for (int i = 0; i < 4; i++) begin
            tune_word = $urandom;
            xfer_n = 1'b0;
            cyc("R1");
            xfer_n = 1'b1;
            tune_word = $urandom;
            for (int j = 0; j < 7; j++) cyc("R1");
        end

        // R5: constrained random mix
        for (int i = 0; i < 3000; i++) begin
            tune_word = $urandom;
            xfer_n = ($urandom % 4) != 0;
            clr_n  = ($urandom % 10) != 0;
            run_n  = ($urandom % 6) == 0;
            cyc("R5");
        end
        xfer_n = 1'b1;
        clr_n = 1'b1;
        run_n = 1'b1;
        for (int i = 0; i < 8; i++) cyc("R5");

        finish_run();
    end

endmodule